// File: doc/BRIEF.md
# Two-Line Vectored Interrupt Controller

This controller collects a set of level-sensitive peripheral interrupt sources and presents them to a processor core that has only two request inputs. The first is a fast request line. The second is a normal request line. Software chooses, for each source, whether it is enabled and which of the two lines it drives. For each source it also sets a priority and the address of that source's handler. Normally a single latency-critical source is sent to the fast line, and every other source shares the normal line.

Among the enabled sources that drive the normal line, the controller picks a winner. The highest priority value wins, and on a tie the lower source index wins. The winner's handler address appears on the vector register. When software reads that register, service begins: the vector is latched, and no further normal request is raised until software writes the end-of-interrupt register. If software reads the vector while no normal source is active, the read returns a programmable default-handler address and does not begin service. This lets a spurious request be caught. The fast line has no acknowledge and reflects its sources at all times.

Top module: `irq_fiq_vector_ctrl`

## Requirements
- R1: `fiq_o` is high in the same cycle as any source that is both enabled and routed to the fast line, whether or not a normal-line service is in progress.
- R2: `irq_o` is high when at least one enabled source routed to the normal line is active and no service is in progress.
- R3: A source whose enable bit (register 0x00, bit = source index) is 0 has no effect on `irq_o`, on `fiq_o` or on the vector value.
- R4: When no service is in progress, the vector register (0x02) returns the handler address of the active normal-line source with the largest priority value. Priorities are held at 0x10+index and handler addresses at 0x20+index.
- R5: Active normal-line sources with equal priority values are resolved in favour of the lower index.
- R6: While no service is in progress, a read of the vector register latches the returned value. If a normal-line source was active at that read, service begins.
- R7: A vector read while no normal-line source is active returns the default-handler address (register 0x04) and does not begin service.
- R8: During service, `irq_o` stays low and vector reads return the latched value, even when a higher-priority source becomes active.
- R9: A write of any value to the end-of-interrupt register (0x03) ends service in the next cycle, so `irq_o` rises again if a normal-line source is active.
- R10: A source whose route bit (register 0x01, bit = source index) is 1 never drives `irq_o` and is never chosen as the vector.
- R11: After reset, the enable, route, priority, handler and default registers all read zero, and both request outputs are low.
- R12: The enable, route, default, priority and handler registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src | input | NSRC | Level-sensitive source requests |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a vector read has a side effect) |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | VEC_W | Write data |
| reg_rdata | output | VEC_W | Read data, combinational from address |
| irq_o | output | 1 | Normal request to the core |
| fiq_o | output | 1 | Fast request to the core |

## Verification
The assertions assume that a read strobe and a write strobe never target the vector and end-of-interrupt registers in the same cycle. They also assume that sources are level signals held by the peripheral until software clears them. The stimulus changes sources and strobes only just after a rising edge and holds them for whole cycles. It issues one register access at a time, so these assumptions always hold. The reference model in the bench recomputes both request lines and every read value from the same programmed state on each clock.

// File: rtl/irq_fiq_vector_ctrl.sv
module irq_fiq_vector_ctrl #(
  parameter int NSRC   = 8,
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [5:0]       reg_addr,
  input  logic [VEC_W-1:0] reg_wdata,
  output logic [VEC_W-1:0] reg_rdata,
  output logic             irq_o,
  output logic             fiq_o
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [5:0] A_EN   = 6'h00;
  localparam logic [5:0] A_ROUTE= 6'h01;
  localparam logic [5:0] A_VEC  = 6'h02;
  localparam logic [5:0] A_EOI  = 6'h03;
  localparam logic [5:0] A_DFLT = 6'h04;
  localparam int PRIO_BASE = 16;
  localparam int HDL_BASE  = 32;

  logic [NSRC-1:0]   en_q, route_q;
  logic [PRIO_W-1:0] prio_q [NSRC];
  logic [VEC_W-1:0]  hdl_q  [NSRC];
  logic [VEC_W-1:0]  dflt_q, vec_q;
  logic              svc_q;

  logic [NSRC-1:0]   irq_pend;
  logic              found;
  logic [IDX_W-1:0]  win;
  logic [PRIO_W-1:0] best;
  logic [VEC_W-1:0]  live_vec;
  logic              vec_read, eoi_wr;

  assign irq_pend = src & en_q & ~route_q;
  assign fiq_o    = |(src & en_q & route_q);
  assign vec_read = reg_rd && (reg_addr == A_VEC);
  assign eoi_wr   = reg_wr && (reg_addr == A_EOI);

  always_comb begin
    found = 1'b0;
    win   = '0;
    best  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (irq_pend[i] && (!found || prio_q[i] > best)) begin
        found = 1'b1;
        win   = IDX_W'(i);
        best  = prio_q[i];
      end
    end
  end

  assign live_vec = found ? hdl_q[win] : dflt_q;
  assign irq_o    = found && !svc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
      dflt_q  <= '0;
      for (int i = 0; i < NSRC; i++) begin
        prio_q[i] <= '0;
        hdl_q[i]  <= '0;
      end
    end else if (reg_wr) begin
      if (reg_addr == A_EN)    en_q    <= reg_wdata[NSRC-1:0];
      if (reg_addr == A_ROUTE) route_q <= reg_wdata[NSRC-1:0];
      if (reg_addr == A_DFLT)  dflt_q  <= reg_wdata;
      for (int i = 0; i < NSRC; i++) begin
        if (reg_addr == 6'(PRIO_BASE + i)) prio_q[i] <= reg_wdata[PRIO_W-1:0];
        if (reg_addr == 6'(HDL_BASE + i))  hdl_q[i]  <= reg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      svc_q <= 1'b0;
      vec_q <= '0;
    end else begin
      if (vec_read && !svc_q) begin
        vec_q <= live_vec;
        svc_q <= found;
      end
      if (eoi_wr) svc_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_EN:    reg_rdata[NSRC-1:0] = en_q;
      A_ROUTE: reg_rdata[NSRC-1:0] = route_q;
      A_VEC:   reg_rdata = svc_q ? vec_q : live_vec;
      A_DFLT:  reg_rdata = dflt_q;
      default: begin
        for (int i = 0; i < NSRC; i++) begin
          if (reg_addr == 6'(PRIO_BASE + i)) reg_rdata[PRIO_W-1:0] = prio_q[i];
          if (reg_addr == 6'(HDL_BASE + i))  reg_rdata = hdl_q[i];
        end
      end
    endcase
  end

  assert_service_starts_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(svc_q) |-> $past(vec_read));

  assert_vector_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_q && !eoi_wr) |=> $stable(vec_q) && svc_q);

  assert_eoi_ends_service_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr |=> !svc_q);

  assert_spurious_no_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_read && !svc_q && !(|(src & en_q & ~route_q))) |=> !svc_q);

  assert_winner_is_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (src[win] && en_q[win] && !route_q[win]));

  assert_service_silences_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(svc_q) && svc_q |-> !irq_o);
endmodule

// File: tb/test_irq_fiq_vector_ctrl.sv
module test_irq_fiq_vector_ctrl;
  localparam int N = 8;
  localparam int W = 32;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [5:0] reg_addr = '0;
  logic [W-1:0] reg_wdata = '0, reg_rdata;
  logic irq_o, fiq_o;

  irq_fiq_vector_ctrl #(.NSRC(N), .PRIO_W(4), .VEC_W(W)) i_irq_fiq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .src(src), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  bit m_en [N], m_rt [N];
  int m_pr [N];
  logic [W-1:0] m_h [N];
  logic [W-1:0] m_dflt, m_vec;
  bit m_svc;

  function automatic int m_pick();
    int w = -1;
    for (int i = N - 1; i >= 0; i--)
      if (src[i] && m_en[i] && !m_rt[i] && (w < 0 || m_pr[i] >= m_pr[w])) w = i;
    return w;
  endfunction

  function automatic logic [W-1:0] m_read(input logic [5:0] a);
    logic [W-1:0] r = '0;
    int w;
    if (a == 6'h00) for (int i = 0; i < N; i++) r[i] = m_en[i];
    else if (a == 6'h01) for (int i = 0; i < N; i++) r[i] = m_rt[i];
    else if (a == 6'h02) begin
      w = m_pick();
      r = m_svc ? m_vec : (w < 0 ? m_dflt : m_h[w]);
    end
    else if (a == 6'h04) r = m_dflt;
    else if (a >= 16 && a < 16 + N) r = W'(m_pr[a - 16]);
    else if (a >= 32 && a < 32 + N) r = m_h[a - 32];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_en[i] = 0; m_rt[i] = 0; m_pr[i] = 0; m_h[i] = '0; end
      m_dflt = '0; m_vec = '0; m_svc = 0;
    end else begin
      if (reg_rd && reg_addr == 6'h02 && !m_svc) begin
        m_vec = m_read(6'h02);
        m_svc = (m_pick() >= 0);
      end
      if (reg_wr) begin
        if (reg_addr == 6'h00) for (int i = 0; i < N; i++) m_en[i] = reg_wdata[i];
        if (reg_addr == 6'h01) for (int i = 0; i < N; i++) m_rt[i] = reg_wdata[i];
        if (reg_addr == 6'h03) m_svc = 0;
        if (reg_addr == 6'h04) m_dflt = reg_wdata;
        if (reg_addr >= 16 && reg_addr < 16 + N) m_pr[reg_addr - 16] = int'(reg_wdata[3:0]);
        if (reg_addr >= 32 && reg_addr < 32 + N) m_h[reg_addr - 32] = reg_wdata;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    bit mf, mi;
    if (rst_n && !done) begin
      mf = 0;
      for (int i = 0; i < N; i++) if (src[i] && m_en[i] && m_rt[i]) mf = 1;
      mi = (m_pick() >= 0) && !m_svc;
      checks++;
      if (fiq_o !== mf) begin fails++; $display("FAIL R1 model fiq: actual=%0b expected=%0b", fiq_o, mf); end
      checks++;
      if (irq_o !== mi) begin fails++; $display("FAIL R2 model irq: actual=%0b expected=%0b", irq_o, mi); end
      if (reg_rd) begin
        checks++;
        if (reg_rdata !== m_read(reg_addr)) begin
          fails++; $display("FAIL R12 model read @%0h: actual=%0h expected=%0h", reg_addr, reg_rdata, m_read(reg_addr));
        end
      end
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin fails++; $display("FAIL %s: actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic wr(input logic [5:0] a, input logic [W-1:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [W-1:0] d);
    reg_rd = 1; reg_addr = a;
    @(negedge clk); d = reg_rdata;
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    settle();
    chk("R11 irq after reset", W'(irq_o), 0);
    chk("R11 fiq after reset", W'(fiq_o), 0);
    tick();
    rd(6'h00, d); chk("R11 enable reset", d, 0);
    rd(6'h22, d); chk("R11 handler reset", d, 0);
    rd(6'h13, d); chk("R11 priority reset", d, 0);

    for (int i = 0; i < N; i++) wr(6'(32 + i), W'(32'h1000 + i * 16));
    wr(6'h04, 32'hDEAD0000);
    wr(6'h12, 3); wr(6'h15, 7); wr(6'h16, 9); wr(6'h11, 2); wr(6'h14, 2);
    rd(6'h15, d); chk("R12 priority readback", d, 7);
    rd(6'h04, d); chk("R12 default readback", d, 32'hDEAD0000);

    // masked source
    src = 8'b0000_0100; settle();
    chk("R3 masked irq", W'(irq_o), 0);
    tick();
    rd(6'h02, d); chk("R3 masked vector gives default", d, 32'hDEAD0000);
    wr(6'h00, 8'hFF); settle();
    chk("R2 irq raised", W'(irq_o), 1);
    tick();

    // priority and latching
    src = 8'b0010_0100; tick();
    rd(6'h02, d); chk("R4 highest priority vector", d, 32'h1050);
    settle(); chk("R8 irq low in service", W'(irq_o), 0);
    tick();
    src = 8'b0110_0100; settle();
    chk("R8 irq stays low", W'(irq_o), 0);
    tick();
    rd(6'h02, d); chk("R8 latched vector held", d, 32'h1050);
    wr(6'h03, 0); settle();
    chk("R9 irq back after eoi", W'(irq_o), 1);
    tick();
    rd(6'h02, d); chk("R6 new winner after eoi", d, 32'h1060);
    wr(6'h03, 0);

    // tie
    src = 8'b0001_0010; tick();
    rd(6'h02, d); chk("R5 tie to lower index", d, 32'h1010);
    wr(6'h03, 0);

    // spurious read
    src = 8'b0; tick();
    rd(6'h02, d); chk("R7 spurious default", d, 32'hDEAD0000);
    src = 8'b0000_0100; settle();
    chk("R7 no service started", W'(irq_o), 1);
    tick();

    // fast line
    wr(6'h10, 15); wr(6'h01, 8'h01);
    src = 8'b0000_0001; settle();
    chk("R1 fiq raised", W'(fiq_o), 1);
    chk("R10 fiq source not on irq", W'(irq_o), 0);
    tick();
    rd(6'h02, d); chk("R10 fiq source not vectored", d, 32'hDEAD0000);
    src = 8'b0000_1001; tick();
    rd(6'h02, d); chk("R10 irq winner skips fiq source", d, 32'h1030);
    settle(); chk("R1 fiq during service", W'(fiq_o), 1);
    tick();
    wr(6'h00, 8'hFE); settle();
    chk("R3 masked fiq", W'(fiq_o), 0);
    tick();
    wr(6'h03, 0);
    rd(6'h01, d); chk("R12 route readback", d, 1);
    src = 8'b0; tick(); tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule